// File: doc/BRIEF.md
# Video Output Control and Status Registers

This block is the register bank that software uses to steer a clocked video output stage. A small word-addressed slave port gives access to nine 16-bit registers. Writable registers drive the stage directly: the run enable, the sync and frame-lock enables, the scan format (interlaced or progressive), the colour-plane ordering (sequential or parallel), the active picture width and the active line counts of both fields.

The stage reports back through single-cycle event pulses for FIFO underflow, status update and lock achieved. It also supplies the live FIFO fill level, a one-hot code of the selected mode, a level showing that pixels are being sent and a level showing that start of frame is aligned to the reference. Events are kept in sticky flags. Software clears a flag by writing 1 to its bit. A single registered interrupt line combines the two interrupt flags, each gated by its own enable bit.

Top module: `vout_csr`

## Requirements
- R1: After synchronous reset every writable register and every flag is zero, all control outputs and `irq` are 0, and every address reads back as zero while the live inputs are zero.
- R2: Word 0 (control) keeps bits [4:0]: bit 0 run, bit 1 status-update interrupt enable, bit 2 locked interrupt enable, bit 3 sync enable, bit 4 lock request. Bits 0 and 3 drive `run_en` and `sync_en`. Bits [15:5] read back as 0.
- R3: `lock_en` is 1 only while control bit 4 and control bit 3 are both 1.
- R4: Word 5 (mode) keeps bit 0 (1 = interlaced) and bit 1 (1 = sequential planes), and bits [15:2] read 0. Words 6, 7 and 8 hold the full 16-bit active width, field 0 line count and field 1 line count. All of them drive the matching outputs and read back what was written.
- R5: Word 1 (status) reads `out_active` in bit 0, 0 in bit 1, and `sof_aligned` in bit 3. Bits [15:4] read 0. Writes do not change bits 0, 1 or 3.
- R6: Status bit 2 is set by an `ev_underflow` pulse and stays set until a write to word 1 with data bit 2 = 1. A write with bit 2 = 0 leaves it set.
- R7: Word 2 (interrupt) bit 1 is set by `ev_status_upd` and bit 2 by `ev_lock_done`. Each is cleared only by writing 1 to that bit. Bits 0 and [15:3] read 0.
- R8: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq` is a register equal to the OR of (interrupt bit 1 AND control bit 1) and (interrupt bit 2 AND control bit 2), taken one clock after those bits change.
- R10: Word 3 returns `fifo_fill` and word 4 returns `mode_onehot`, both zero-extended. Writes to these words have no effect.
- R11: `bus_rdata` is valid on the clock after a read strobe and is 0 in any cycle that follows a cycle without a read. Addresses 9 to 15 read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ev_underflow | input | 1 | FIFO underflow pulse |
| ev_status_upd | input | 1 | Status update pulse |
| ev_lock_done | input | 1 | Lock achieved pulse |
| out_active | input | 1 | Stage is sending pixels |
| sof_aligned | input | 1 | Start of frame aligned to reference |
| fifo_fill | input | FILL_W (10) | Live FIFO fill level |
| mode_onehot | input | MATCH_W (4) | One-hot selected mode |
| run_en | output | 1 | Run enable |
| sync_en | output | 1 | Sync outputs enable |
| lock_en | output | 1 | Effective frame-lock enable |
| interlaced | output | 1 | 1 = interlaced scan |
| seq_planes | output | 1 | 1 = sequential colour planes |
| active_width | output | 16 | Active samples per line |
| f0_lines | output | 16 | Field 0 / progressive line count |
| f1_lines | output | 16 | Field 1 line count |
| irq | output | 1 | Interrupt request |

## Verification
Control writes use all-ones data, so the masking of unused bits is exercised, and then sparse patterns, which show whether each bit lands in its own output. Setting the lock request with and without the sync enable shows whether the lock gating is in place. Each flag goes through three cases: an event alone, a write of 0, and a write of 1. Each flag is also hit by an event and a clear in the same cycle, which shows whether clear or set takes priority. The interrupt line is watched cycle by cycle with its enable off and then on, which pins down both the gating and the one-cycle delay. Writes to the read-only words and to unmapped addresses, followed by readback, show that such writes leave no trace.

// File: rtl/vout_csr_pkg.sv
package vout_csr_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 4;
    localparam int NUM_REG = 9;
    localparam int NUM_SZ  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 4'd0,
        A_STAT  = 4'd1,
        A_INT   = 4'd2,
        A_FILL  = 4'd3,
        A_MATCH = 4'd4,
        A_MODE  = 4'd5,
        A_WIDTH = 4'd6,
        A_F0    = 4'd7,
        A_F1    = 4'd8
    } reg_addr_e;

    // Bit order matches the control word, LSB last
    typedef struct packed {
        logic lock_req;
        logic sync_en;
        logic lock_ie;
        logic upd_ie;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic seq;
        logic ilace;
    } mode_t;

    typedef struct packed {
        logic lock_f;
        logic upd_f;
        logic uf;
    } flags_t;

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[4:0] = c;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] mode_word(input mode_t m);
        logic [DATA_W-1:0] w;
        w = '0;
        w[1:0] = m;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input logic act, input logic uf,
                                                    input logic aligned);
        logic [DATA_W-1:0] w;
        w = '0;
        w[0] = act;
        w[2] = uf;
        w[3] = aligned;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] int_word(input flags_t f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[1] = f.upd_f;
        w[2] = f.lock_f;
        return w;
    endfunction

endpackage

// File: rtl/vout_csr_cfg.sv
module vout_csr_cfg
    import vout_csr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_ctrl,
    input  logic                   wr_mode,
    input  logic [NUM_SZ-1:0]      wr_size,
    input  logic [DW-1:0]          wdata,
    output ctrl_t                  ctrl_q,
    output mode_t                  mode_q,
    output logic [NUM_SZ-1:0][DW-1:0] size_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(wdata[4:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (wr_mode) begin
            mode_q <= mode_t'(wdata[1:0]);
        end
    end

    for (genvar i = 0; i < NUM_SZ; i++) begin : g_size
        always_ff @(posedge clk) begin
            if (rst) begin
                size_q[i] <= '0;
            end else if (wr_size[i]) begin
                size_q[i] <= wdata;
            end
        end

        p_size_hold_r4: assert property (@(posedge clk) disable iff (rst)
            !wr_size[i] |=> $stable(size_q[i]));
    end

    p_run_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> ctrl_q.run == $past(wdata[0]));

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl_q));

endmodule

// File: rtl/vout_csr_flags.sv
module vout_csr_flags
    import vout_csr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t set_ev,
    input  flags_t clr_req,
    input  logic   upd_ie,
    input  logic   lock_ie,
    output flags_t flags_q,
    output logic   irq
);

    logic [2:0] set_v, clr_v, cur_v;
    assign set_v = set_ev;
    assign clr_v = clr_req;
    assign cur_v = flags_q;

    // Set has priority over a write-1 clear in the same cycle
    for (genvar i = 0; i < 3; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[i] <= 1'b0;
            end else begin
                flags_q[i] <= set_v[i] | (cur_v[i] & ~clr_v[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= (flags_q.upd_f & upd_ie) | (flags_q.lock_f & lock_ie);
        end
    end

    p_uf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flags_q.uf && !clr_req.uf) |=> flags_q.uf);

    p_uf_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set_ev.uf |=> flags_q.uf);

    p_upd_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set_ev.upd_f |=> flags_q.upd_f);

    p_int_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flags_q.lock_f && !clr_req.lock_f) |=> flags_q.lock_f);

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!(flags_q.upd_f && upd_ie) && !(flags_q.lock_f && lock_ie)) |=> !irq);

    p_irq_fire_r9: assert property (@(posedge clk) disable iff (rst)
        ((flags_q.upd_f && upd_ie) || (flags_q.lock_f && lock_ie)) |=> irq);

endmodule

// File: rtl/vout_csr_rdmux.sv
module vout_csr_rdmux
    import vout_csr_pkg::*;
#(
    parameter int DW      = DATA_W,
    parameter int FILL_W  = 10,
    parameter int MATCH_W = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rd,
    input  logic [ADDR_W-1:0]         addr,
    input  ctrl_t                     ctrl_q,
    input  mode_t                     mode_q,
    input  flags_t                    flags_q,
    input  logic                      act,
    input  logic                      aligned,
    input  logic [FILL_W-1:0]         fill,
    input  logic [MATCH_W-1:0]        match,
    input  logic [NUM_SZ-1:0][DW-1:0] size_q,
    output logic [DW-1:0]             rdata
);

    logic [DW-1:0] sel;

    always_comb begin
        sel = '0;
        case (addr)
            A_CTRL:  sel = ctrl_word(ctrl_q);
            A_STAT:  sel = stat_word(act, flags_q.uf, aligned);
            A_INT:   sel = int_word(flags_q);
            A_FILL:  sel = DW'(fill);
            A_MATCH: sel = DW'(match);
            A_MODE:  sel = mode_word(mode_q);
            A_WIDTH: sel = size_q[0];
            A_F0:    sel = size_q[1];
            A_F1:    sel = size_q[2];
            default: sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else begin
            rdata <= rd ? sel : '0;
        end
    end

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
        !rd |=> rdata == '0);

    p_hi_addr_r11: assert property (@(posedge clk) disable iff (rst)
        (rd && addr > A_F1) |=> rdata == '0);

    p_stat_bit1_r5: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_STAT) |=> rdata[1] == 1'b0);

endmodule

// File: rtl/vout_csr.sv
module vout_csr
    import vout_csr_pkg::*;
#(
    parameter int FILL_W  = 10,
    parameter int MATCH_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [3:0]         bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic               ev_underflow,
    input  logic               ev_status_upd,
    input  logic               ev_lock_done,
    input  logic               out_active,
    input  logic               sof_aligned,
    input  logic [FILL_W-1:0]  fifo_fill,
    input  logic [MATCH_W-1:0] mode_onehot,
    output logic               run_en,
    output logic               sync_en,
    output logic               lock_en,
    output logic               interlaced,
    output logic               seq_planes,
    output logic [15:0]        active_width,
    output logic [15:0]        f0_lines,
    output logic [15:0]        f1_lines,
    output logic               irq
);

    logic [NUM_REG-1:0]                 wsel;
    logic [NUM_SZ-1:0]                  wr_size;
    ctrl_t                              ctrl_q;
    mode_t                              mode_q;
    flags_t                             flags_q;
    flags_t                             set_ev;
    flags_t                             clr_req;
    logic [NUM_SZ-1:0][DATA_W-1:0]      size_q;

    // One write select per mapped word
    for (genvar i = 0; i < NUM_REG; i++) begin : g_wsel
        assign wsel[i] = bus_wr && (bus_addr == ADDR_W'(i));
    end

    for (genvar i = 0; i < NUM_SZ; i++) begin : g_wsz
        assign wr_size[i] = wsel[int'(A_WIDTH) + i];
    end

    assign set_ev  = '{lock_f: ev_lock_done, upd_f: ev_status_upd, uf: ev_underflow};
    assign clr_req = '{lock_f: wsel[A_INT] & bus_wdata[2],
                       upd_f:  wsel[A_INT] & bus_wdata[1],
                       uf:     wsel[A_STAT] & bus_wdata[2]};

    vout_csr_cfg #(.DW(DATA_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wsel[A_CTRL]),
        .wr_mode (wsel[A_MODE]),
        .wr_size (wr_size),
        .wdata   (bus_wdata),
        .ctrl_q  (ctrl_q),
        .mode_q  (mode_q),
        .size_q  (size_q)
    );

    vout_csr_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_ev  (set_ev),
        .clr_req (clr_req),
        .upd_ie  (ctrl_q.upd_ie),
        .lock_ie (ctrl_q.lock_ie),
        .flags_q (flags_q),
        .irq     (irq)
    );

    vout_csr_rdmux #(.DW(DATA_W), .FILL_W(FILL_W), .MATCH_W(MATCH_W)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .ctrl_q  (ctrl_q),
        .mode_q  (mode_q),
        .flags_q (flags_q),
        .act     (out_active),
        .aligned (sof_aligned),
        .fill    (fifo_fill),
        .match   (mode_onehot),
        .size_q  (size_q),
        .rdata   (bus_rdata)
    );

    assign run_en       = ctrl_q.run;
    assign sync_en      = ctrl_q.sync_en;
    assign lock_en      = ctrl_q.lock_req & ctrl_q.sync_en;
    assign interlaced   = mode_q.ilace;
    assign seq_planes   = mode_q.seq;
    assign active_width = size_q[0];
    assign f0_lines     = size_q[1];
    assign f1_lines     = size_q[2];

    p_lock_needs_sync_r3: assert property (@(posedge clk) disable iff (rst)
        lock_en |-> sync_en);

endmodule

// File: tb/vout_csr_test.sv
`timescale 1ns/1ps
module vout_csr_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ev_underflow = 1'b0, ev_status_upd = 1'b0, ev_lock_done = 1'b0;
    logic        out_active = 1'b0, sof_aligned = 1'b0;
    logic [9:0]  fifo_fill = '0;
    logic [3:0]  mode_onehot = '0;
    logic        run_en, sync_en, lock_en, interlaced, seq_planes, irq;
    logic [15:0] active_width, f0_lines, f1_lines;

    int nchk = 0, nbad = 0;
    bit done = 0;
    logic rd_seen = 1'b0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    vout_csr uut (.*);

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard on the clock after each read strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_seen) begin
                if (exp_q.size() == 0) chk("R11 unexpected data", 32'(bus_rdata), 32'hDEAD);
                else chk(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
            end else begin
                chk("R11 idle read data", 32'(bus_rdata), 0);
            end
        end
    end

    // Driver tasks, each entered and left at a falling edge
    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input int which);
        case (which)
            0: ev_underflow = 1'b1;
            1: ev_status_upd = 1'b1;
            default: ev_lock_done = 1'b1;
        endcase
        @(negedge clk);
        ev_underflow = 1'b0; ev_status_upd = 1'b0; ev_lock_done = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        nchk++; nbad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 outputs", {run_en, sync_en, lock_en, interlaced, seq_planes, irq}, 0);
        chk("R1 sizes", {active_width, f0_lines}, 0);
        for (int a = 0; a < 9; a++) rd(4'(a), 16'h0, "R1 reset readback");

        // R2/R3: control fields and lock gating
        wr(4'd0, 16'hFFFF);
        rd(4'd0, 16'h001F, "R2 control masked readback");
        chk("R2 run/sync", {run_en, sync_en}, 2'b11);
        chk("R3 lock with sync", lock_en, 1);
        wr(4'd0, 16'h0011);
        chk("R3 lock without sync", lock_en, 0);
        chk("R2 run only", {run_en, sync_en}, 2'b10);
        wr(4'd0, 16'h0008);
        chk("R2 sync only", {run_en, sync_en, lock_en}, 3'b010);

        // R4: mode and sizes
        wr(4'd5, 16'hFFFF);
        rd(4'd5, 16'h0003, "R4 mode masked readback");
        chk("R4 mode outs", {interlaced, seq_planes}, 2'b11);
        wr(4'd5, 16'h0002);
        chk("R4 progressive sequential", {interlaced, seq_planes}, 2'b01);
        wr(4'd6, 16'd720); wr(4'd7, 16'd243); wr(4'd8, 16'hA5C3);
        chk("R4 width", active_width, 720);
        chk("R4 f0", f0_lines, 243);
        chk("R4 f1", f1_lines, 16'hA5C3);
        rd(4'd6, 16'd720, "R4 width readback");
        rd(4'd8, 16'hA5C3, "R4 f1 readback");

        // R5: live status bits
        out_active = 1'b1; sof_aligned = 1'b1;
        rd(4'd1, 16'h0009, "R5 status live");
        wr(4'd1, 16'hFFFB);
        rd(4'd1, 16'h0009, "R5 status after write");
        out_active = 1'b0;
        rd(4'd1, 16'h0008, "R5 active dropped");
        sof_aligned = 1'b0;

        // R6: sticky underflow
        pulse(0);
        rd(4'd1, 16'h0004, "R6 underflow set");
        repeat (3) @(negedge clk);
        wr(4'd1, 16'h0000);
        rd(4'd1, 16'h0004, "R6 write 0 keeps");
        wr(4'd1, 16'h0004);
        rd(4'd1, 16'h0000, "R6 write 1 clears");

        // R7/R9: interrupt flags and gated irq
        wr(4'd0, 16'h0001);
        pulse(1);
        rd(4'd2, 16'h0002, "R7 status-update flag");
        @(negedge clk);
        chk("R9 irq gated off", irq, 0);
        wr(4'd0, 16'h0003);
        chk("R9 irq one cycle after enable", irq, 0);
        @(negedge clk);
        chk("R9 irq after enable", irq, 1);
        wr(4'd2, 16'h0004);
        rd(4'd2, 16'h0002, "R7 clearing other bit keeps");
        wr(4'd2, 16'h0002);
        @(negedge clk);
        chk("R9 irq drops after clear", irq, 0);
        rd(4'd2, 16'h0000, "R7 flag cleared");
        wr(4'd0, 16'h0005);
        pulse(2);
        chk("R9 irq latency", irq, 0);
        @(negedge clk);
        chk("R9 locked irq", irq, 1);
        rd(4'd2, 16'h0004, "R7 locked flag");
        wr(4'd2, 16'hFFFF);
        rd(4'd2, 16'h0000, "R7 both cleared");

        // R8: set wins over clear in the same cycle
        bus_addr = 4'd2; bus_wdata = 16'h0002; bus_wr = 1'b1; ev_status_upd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_status_upd = 1'b0;
        rd(4'd2, 16'h0002, "R8 interrupt set wins");
        bus_addr = 4'd1; bus_wdata = 16'h0004; bus_wr = 1'b1; ev_underflow = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_underflow = 1'b0;
        rd(4'd1, 16'h0004, "R8 underflow set wins");
        wr(4'd1, 16'h0004); wr(4'd2, 16'h0006);

        // R10: read-only words
        fifo_fill = 10'h234; mode_onehot = 4'b0100;
        rd(4'd3, 16'h0234, "R10 fill level");
        rd(4'd4, 16'h0004, "R10 mode match");
        wr(4'd3, 16'hFFFF); wr(4'd4, 16'hFFFF);
        rd(4'd3, 16'h0234, "R10 fill after write");
        rd(4'd4, 16'h0004, "R10 match after write");
        fifo_fill = 10'h3FF;
        rd(4'd3, 16'h03FF, "R10 fill live");

        // R11: unmapped addresses
        wr(4'd9, 16'hFFFF); wr(4'd12, 16'h1234); wr(4'd15, 16'hFFFF);
        for (int a = 9; a < 16; a++) rd(4'(a), 16'h0, "R11 unmapped reads zero");
        rd(4'd0, 16'h0005, "R11 unmapped write no effect on control");
        rd(4'd6, 16'd720, "R11 unmapped write no effect on width");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule